// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of page table out of physical memory. A requester presents a virtual address, a write flag, a user-mode flag and the physical address of the root table. The walker fetches the root entry, then the leaf entry that the root entry points at, checks presence and access rights at both levels, and returns the physical frame joined with the unchanged 4 KiB page offset.

When a leaf is used for a write and its dirty bit is still clear, the walker writes the entry back with the dirty bit set before it answers. A missing entry or a forbidden access ends the walk with a fault code instead of an address, so that software can deal with it. The memory side is a single request channel with a ready signal and a read-data return; at most one read is in flight.

Top module: `pt_walk_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1; `req_ready` stays 0 from the next cycle until the cycle after the answer, and each taken request yields exactly one `rsp_valid` pulse lasting one cycle.
- R3: The first memory read of a walk addresses `root_base + vaddr[31:22]*4`, using the root base and virtual address held at acceptance; later changes on the request inputs have no effect on the walk.
- R4: The second memory read addresses `{E1[31:12], 12'h000} + vaddr[21:12]*4`, where E1 is the first-level entry.
- R5: Entry bits are: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 3 dirty, bits 31:12 frame. A successful walk returns fault code 2'b00 and `rsp_paddr = {E2[31:12], vaddr[11:0]}`, where E2 is the leaf entry.
- R6: An entry at either level with bit 0 clear ends the walk with fault code 2'b01 and `rsp_paddr` equal to 0; after a first-level fault no second read is made.
- R7: A present entry at either level that forbids the access (a write with bit 1 clear, or a user access with bit 2 clear) ends the walk with fault code 2'b10 and `rsp_paddr` 0; the not-present check at a level wins over the rights check.
- R8: A successful write whose leaf entry has bit 3 clear issues exactly one memory write, to the leaf entry's address, with data equal to the leaf entry with bits 3 and 0 set, before the answer; every other walk issues no write.
- R9: At most one memory read is outstanding, and a memory request held while `mem_req_ready` is 0 keeps its address and direction until taken.
- R10: The fault code 2'b11 never appears with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| root_base | input | 32 | Physical address of the first-level table |
| rsp_valid | output | 1 | One-cycle answer pulse |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 00 none, 01 not present, 10 protection |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_addr | output | 32 | Entry address in physical memory |
| mem_req_we | output | 1 | Request is the dirty-bit write-back |
| mem_req_wdata | output | 32 | Entry value for the write-back |
| mem_rsp_valid | input | 1 | Read data is returned this cycle |
| mem_rsp_data | input | 32 | Returned table entry |

## Verification
On every cycle the assertions watch the handshake shape: the ready drop after acceptance, the single-cycle answer, the legal fault codes with a zero address on faults, the kept page offset, the first read address, held memory requests, a single outstanding read and the form of the dirty write. Whether the right fault is chosen at the right level, whether the second read follows the first entry's frame, and whether the dirty write happens only once per page can only be shown by the bench's sweep against a computed page-table image, where repeated writes to a page must see the bit that an earlier walk set.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    localparam int VA_W        = 32;
    localparam int PA_W        = 32;
    localparam int IDX_W       = 10;
    localparam int OFF_W       = 12;
    localparam int PTE_W       = 32;
    localparam int ENTRY_SHIFT = 2;
    localparam int FRAME_W     = PA_W - OFF_W;
    localparam int SPARE_W     = PTE_W - FRAME_W - 4;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_READ_L1,
        WS_WAIT_L1,
        WS_READ_L2,
        WS_WAIT_L2,
        WS_SET_DIRTY,
        WS_DONE,
        WS_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_ABSENT = 2'b01,
        FLT_PROT   = 2'b10
    } fault_e;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [SPARE_W-1:0] spare;
        logic               dirty;
        logic               user;
        logic               writable;
        logic               present;
    } pte_t;

    typedef struct packed {
        logic [IDX_W-1:0] dir_idx;
        logic [IDX_W-1:0] tbl_idx;
        logic [OFF_W-1:0] offset;
    } vaddr_t;

    typedef struct packed {
        logic   write;
        logic   user;
        vaddr_t va;
    } walk_req_t;

    function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] base,
                                                   input logic [IDX_W-1:0] idx);
        return base + (PA_W'(idx) << ENTRY_SHIFT);
    endfunction

    function automatic logic [PA_W-1:0] frame_base(input logic [FRAME_W-1:0] frame);
        return {frame, {OFF_W{1'b0}}};
    endfunction

endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr
    import pt_walk_pkg::*;
(
    input  logic            second_level,
    input  logic [PA_W-1:0] root_base,
    input  logic [PA_W-1:0] leaf_tbl_base,
    input  vaddr_t          va,
    output logic [PA_W-1:0] addr
);
    logic [PA_W-1:0] root_entry;
    logic [PA_W-1:0] leaf_entry;

    always_comb begin
        root_entry = entry_addr(root_base, va.dir_idx);
        leaf_entry = entry_addr(leaf_tbl_base, va.tbl_idx);
        addr       = second_level ? leaf_entry : root_entry;
    end
endmodule

// File: rtl/pt_walk_perm.sv
module pt_walk_perm
    import pt_walk_pkg::*;
(
    input  pte_t   pte,
    input  logic   is_write,
    input  logic   is_user,
    output fault_e verdict,
    output logic   need_dirty
);
    logic denied;

    always_comb begin
        denied = (is_write && !pte.writable) || (is_user && !pte.user);
        if (!pte.present) begin
            verdict = FLT_ABSENT;
        end else if (denied) begin
            verdict = FLT_PROT;
        end else begin
            verdict = FLT_NONE;
        end
        need_dirty = is_write && !pte.dirty;
    end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
    import pt_walk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_fire,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  fault_e      verdict,
    input  logic        need_dirty,
    output walk_state_e state
);
    walk_state_e state_q;
    walk_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:      if (req_fire) state_d = WS_READ_L1;
            WS_READ_L1:   if (mem_req_ready) state_d = WS_WAIT_L1;
            WS_WAIT_L1: begin
                if (mem_rsp_valid) begin
                    state_d = (verdict == FLT_NONE) ? WS_READ_L2 : WS_FAULT;
                end
            end
            WS_READ_L2:   if (mem_req_ready) state_d = WS_WAIT_L2;
            WS_WAIT_L2: begin
                if (mem_rsp_valid) begin
                    if (verdict != FLT_NONE) begin
                        state_d = WS_FAULT;
                    end else if (need_dirty) begin
                        state_d = WS_SET_DIRTY;
                    end else begin
                        state_d = WS_DONE;
                    end
                end
            end
            WS_SET_DIRTY: if (mem_req_ready) state_d = WS_DONE;
            WS_DONE:      state_d = WS_IDLE;
            WS_FAULT:     state_d = WS_IDLE;
            default:      state_d = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/pt_walk_top.sv
module pt_walk_top
    import pt_walk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [PA_W-1:0]   root_base,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_fault,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    output logic              mem_req_we,
    output logic [PTE_W-1:0]  mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data
);
    walk_state_e     state;
    walk_req_t       cur_q;
    logic [PA_W-1:0] root_q;
    logic [PA_W-1:0] leaf_tbl_q;
    pte_t            leaf_q;
    fault_e          fault_q;
    pte_t            rsp_pte;
    pte_t            wb_pte;
    fault_e          verdict;
    logic            need_dirty;
    logic            req_fire;
    logic            second_level;

    assign rsp_pte      = pte_t'(mem_rsp_data);
    assign req_fire     = req_valid && req_ready;
    assign second_level = (state == WS_READ_L2) || (state == WS_SET_DIRTY);

    pt_walk_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .req_fire      (req_fire),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .verdict       (verdict),
        .need_dirty    (need_dirty),
        .state         (state)
    );

    pt_walk_perm u_perm (
        .pte        (rsp_pte),
        .is_write   (cur_q.write),
        .is_user    (cur_q.user),
        .verdict    (verdict),
        .need_dirty (need_dirty)
    );

    pt_walk_addr u_addr (
        .second_level  (second_level),
        .root_base     (root_q),
        .leaf_tbl_base (leaf_tbl_q),
        .va            (cur_q.va),
        .addr          (mem_req_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q      <= '0;
            root_q     <= '0;
            leaf_tbl_q <= '0;
            leaf_q     <= '0;
            fault_q    <= FLT_NONE;
        end else begin
            if (req_fire) begin
                cur_q.write <= req_write;
                cur_q.user  <= req_user;
                cur_q.va    <= vaddr_t'(req_vaddr);
                root_q      <= root_base;
                fault_q     <= FLT_NONE;
            end
            if (state == WS_WAIT_L1 && mem_rsp_valid) begin
                leaf_tbl_q <= frame_base(rsp_pte.frame);
                if (verdict != FLT_NONE) begin
                    fault_q <= verdict;
                end
            end
            if (state == WS_WAIT_L2 && mem_rsp_valid) begin
                leaf_q <= rsp_pte;
                if (verdict != FLT_NONE) begin
                    fault_q <= verdict;
                end
            end
        end
    end

    always_comb begin
        wb_pte       = leaf_q;
        wb_pte.dirty = 1'b1;
    end

    assign req_ready     = (state == WS_IDLE);
    assign mem_req_valid = (state == WS_READ_L1) || (state == WS_READ_L2) ||
                           (state == WS_SET_DIRTY);
    assign mem_req_we    = (state == WS_SET_DIRTY);
    assign mem_req_wdata = PTE_W'(wb_pte);
    assign rsp_valid     = (state == WS_DONE) || (state == WS_FAULT);
    assign rsp_paddr     = (state == WS_DONE) ? {leaf_q.frame, cur_q.va.offset} : '0;
    assign rsp_fault     = (state == WS_FAULT) ? fault_q : FLT_NONE;
endmodule

// File: rtl/pt_walk_sva.sv
module pt_walk_sva
    import pt_walk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [VA_W-1:0]   req_vaddr,
    input logic              req_write,
    input logic              req_user,
    input logic [PA_W-1:0]   root_base,
    input logic              rsp_valid,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic [1:0]        rsp_fault,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [PA_W-1:0]   mem_req_addr,
    input logic              mem_req_we,
    input logic [PTE_W-1:0]  mem_req_wdata,
    input logic              mem_rsp_valid,
    input logic [PTE_W-1:0]  mem_rsp_data
);
    logic [VA_W-1:0] cap_va;
    logic [PA_W-1:0] cap_root;
    logic            cap_write;
    logic            rd_pending;
    logic            first_due;
    logic            unused_ok;

    assign unused_ok = ^{req_user, mem_rsp_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_va     <= '0;
            cap_root   <= '0;
            cap_write  <= 1'b0;
            rd_pending <= 1'b0;
            first_due  <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                cap_va    <= req_vaddr;
                cap_root  <= root_base;
                cap_write <= req_write;
                first_due <= 1'b1;
            end
            if (mem_req_valid && mem_req_ready && !mem_req_we) begin
                rd_pending <= 1'b1;
                first_due  <= 1'b0;
            end
            if (mem_rsp_valid) begin
                rd_pending <= 1'b0;
            end
        end
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready); // R2
    AST_ANSWER_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid && req_ready); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req_valid && !rsp_valid); // R2
    AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_fault != 2'b11); // R10
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault != 2'b00 |-> rsp_paddr == '0); // R6
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault == 2'b00 |-> rsp_paddr[OFF_W-1:0] == cap_va[OFF_W-1:0]); // R5
    AST_FIRST_READ_ADDR: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && first_due |->
        !mem_req_we && mem_req_addr == cap_root + (PA_W'(cap_va[VA_W-1:VA_W-IDX_W]) << ENTRY_SHIFT)); // R3
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=>
        mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)); // R9
    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !rd_pending); // R9
    AST_DIRTY_WRITE_FORM: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_we |-> mem_req_wdata[3] && mem_req_wdata[0] && cap_write); // R8
endmodule

bind pt_walk_top pt_walk_sva u_sva (.*);

// File: tb/pt_walk_top_test.sv
`timescale 1ns/100ps
module pt_walk_top_test;

    localparam logic [31:0] L1BASE = 32'h0001_0000;
    localparam logic [31:0] L2REG  = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] root_base = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_req_we;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pt_walk_top uut (.*);

    // page-table image, computed
    bit dirty_set [int unsigned];

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        int unsigned i, j;
        logic v, w, u, d;
        logic [19:0] fr;
        if (a >= L1BASE && a < L1BASE + 32'd4096) begin
            i  = (a - L1BASE) >> 2;
            v  = (i % 7) != 3;
            w  = (i % 5) != 2;
            u  = (i % 3) != 1;
            fr = 20'h00100 + 20'(i);
            return {fr, 8'h00, 1'b0, u, w, v};
        end else if (a >= L2REG && a < L2REG + 32'h0040_0000) begin
            i  = (a - L2REG) >> 12;
            j  = (a >> 2) & 32'd1023;
            v  = ((i + j) % 11) != 5;
            w  = ((3 * i + j) % 4) != 0;
            u  = ((i + 7 * j) % 6) != 2;
            d  = ((j % 2) == 0) || dirty_set.exists(a);
            fr = 20'h40000 ^ 20'(i * 1024 + j);
            return {fr, 8'h00, d, u, w, v};
        end
        return 32'h0;
    endfunction

    // memory responder
    int          cyc = 0;
    bit          took = 0;
    bit          took_we = 0;
    logic [31:0] took_addr = '0;
    logic [31:0] took_wdata = '0;
    bit          pend = 0;
    int          pend_dly = 0;
    logic [31:0] pend_addr = '0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          proto_err = 0;
    logic [31:0] rd_log [16];
    logic [31:0] last_waddr = '0;
    logic [31:0] last_wdata = '0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        mem_rsp_valid = 1'b0;
        if (took) begin
            if (took_we) begin
                dirty_set[took_addr] = 1'b1;
                wr_cnt     = wr_cnt + 1;
                last_waddr = took_addr;
                last_wdata = took_wdata;
            end else begin
                if (pend) proto_err = proto_err + 1;
                rd_log[rd_cnt % 16] = took_addr;
                rd_cnt    = rd_cnt + 1;
                pend      = 1'b1;
                pend_addr = took_addr;
                pend_dly  = cyc % 2;
            end
        end
        if (pend) begin
            if (pend_dly == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_word(pend_addr);
                pend          = 1'b0;
            end else begin
                pend_dly = pend_dly - 1;
            end
        end
        mem_req_ready = (cyc % 3) != 0;
        took       = mem_req_valid && mem_req_ready;
        took_we    = mem_req_we;
        took_addr  = mem_req_addr;
        took_wdata = mem_req_wdata;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_walk(input int i, input int j, input logic [11:0] off,
                           input logic wr, input logic us);
        logic [31:0] va, e1, e2, a1, a2, exp_pa, got_pa;
        logic [1:0]  exp_f, got_f;
        int          exp_rd, rd0, wr0;
        bit          exp_wr, seen, denied;
        va     = {i[9:0], j[9:0], off};
        a1     = L1BASE + (32'(i) << 2);
        e1     = mem_word(a1);
        a2     = {e1[31:12], 12'h000} + (32'(j) << 2);
        e2     = '0;
        exp_rd = 1;
        exp_wr = 0;
        exp_pa = '0;
        denied = (wr && !e1[1]) || (us && !e1[2]);
        if (!e1[0]) exp_f = 2'b01;
        else if (denied) exp_f = 2'b10;
        else begin
            exp_rd = 2;
            e2     = mem_word(a2);
            denied = (wr && !e2[1]) || (us && !e2[2]);
            if (!e2[0]) exp_f = 2'b01;
            else if (denied) exp_f = 2'b10;
            else begin
                exp_f  = 2'b00;
                exp_pa = {e2[31:12], off};
                exp_wr = wr && !e2[3];
            end
        end
        rd0 = rd_cnt;
        wr0 = wr_cnt;

        @(negedge clk); #1;
        check(req_ready == 1'b1, "R2 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        req_user  = us;
        root_base = L1BASE;
        @(negedge clk); #1;
        req_valid = 1'b0;
        req_vaddr = ~va;
        req_write = ~wr;
        req_user  = ~us;
        root_base = 32'hDEAD_B000;
        check(req_ready == 1'b0, "R2 ready low in walk", 32'(req_ready), 32'd0);

        seen   = 0;
        got_f  = '0;
        got_pa = '0;
        for (int w = 0; w < 100 && !seen; w++) begin
            if (rsp_valid) begin
                seen   = 1;
                got_f  = rsp_fault;
                got_pa = rsp_paddr;
            end else begin
                @(negedge clk); #1;
            end
        end
        check(seen, "R2 answer arrives", 32'(seen), 32'd1);
        @(negedge clk); #1;
        check(!rsp_valid, "R2 answer one cycle", 32'(rsp_valid), 32'd0);

        check(got_f != 2'b11, "R10 legal code", 32'(got_f), 32'd0);
        if (exp_f == 2'b01)
            check(got_f == exp_f, "R6 not-present code", 32'(got_f), 32'(exp_f));
        else if (exp_f == 2'b10)
            check(got_f == exp_f, "R7 protection code", 32'(got_f), 32'(exp_f));
        else
            check(got_f == exp_f, "R5 success code", 32'(got_f), 32'(exp_f));
        if (exp_f == 2'b00)
            check(got_pa == exp_pa, "R5 physical address", got_pa, exp_pa);
        else
            check(got_pa == 32'h0, "R6 zero address on fault", got_pa, 32'h0);

        check(rd_cnt - rd0 == exp_rd, "R6 read count", 32'(rd_cnt - rd0), 32'(exp_rd));
        check(rd_log[rd0 % 16] == a1, "R3 first read address", rd_log[rd0 % 16], a1);
        if (exp_rd == 2)
            check(rd_log[(rd0 + 1) % 16] == a2, "R4 second read address",
                  rd_log[(rd0 + 1) % 16], a2);
        check(wr_cnt - wr0 == int'(exp_wr), "R8 write count",
              32'(wr_cnt - wr0), 32'(exp_wr));
        if (exp_wr) begin
            check(last_waddr == a2, "R8 write address", last_waddr, a2);
            check(last_wdata == (e2 | 32'h8), "R8 write data", last_wdata, e2 | 32'h8);
        end
        check(proto_err == 0, "R9 one read outstanding", 32'(proto_err), 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int i, j;
        logic [11:0] off;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        check(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R1 no answer in reset", 32'(rsp_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk); #1;
        check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R1 no answer after reset", 32'(rsp_valid), 32'd0);
        check(mem_req_valid == 1'b0, "R1 no memory request", 32'(mem_req_valid), 32'd0);

        for (int n = 0; n < 41; n++) begin
            i = (n == 40) ? 1023 : n;
            for (int k = 0; k < 8; k++) begin
                j = (k == 7) ? 1023 : ((k * 97 + i * 13) % 1023);
                for (int c = 0; c < 4; c++) begin
                    off = (k == 0) ? 12'hFFF : 12'((i * 37 + k * 11 + c) & 32'hFFF);
                    do_walk(i, j, off, c[1], c[0]);
                end
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule